// File: doc/BRIEF.md
# Synthesizer Configuration Frequency Decoder

This block works out the output frequency of a clock synthesizer, in whole MHz, from the synthesizer's own registers. A single-cycle start pulse launches a read sequence over a simple request/acknowledge read port. The block reads the status word first. If the synthesizer reports ready, it then reads configuration word 0 and configuration word 2.

From these words it takes an integer multiplier, an optional fractional multiplier in thousandths, a first integer divider, and a second divider. The second divider also has an optional fractional part in thousandths. A separate flag bit enables each fractional part. The block scales everything to fixed point against a 100 MHz reference, forms a 64-bit numerator and a 64-bit denominator, and divides them in a restoring shift-subtract divider that produces one quotient bit per cycle.

The result appears on a one-cycle done strobe, together with a 16-bit frequency and a 2-bit error code. Both are held until the next run finishes. Error codes are 0 for a good result, 1 for a busy synthesizer, and 2 for a zero denominator.

Top module: `synth_freq_decoder`

## Requirements
- R1: After reset, `done_o`, `rd_req_o`, `freq_o` and `err_o` are all 0.
- R2: A run issues exactly three reads, in this order: status at `STATUS_ADDR`, then configuration word 0 at `CFG0_ADDR`, then configuration word 2 at `CFG2_ADDR`. A read is accepted in the cycle where `rd_req_o` and `rd_ack_i` are both high, and `rd_data_i` is taken in that cycle. While unacknowledged, `rd_req_o` stays high and `rd_addr_o` stays steady.
- R3: If bit 0 of the status word is 0, the run ends with `freq_o`=0 and `err_o`=1, and no configuration word is read.
- R4: Configuration word 0 fields are: multiplier M in bits [15:8], first divider D0 in bits [7:0], fractional multiplier MF in bits [25:16]. MF is used only when bit 26 is 1 and is taken as 0 otherwise.
- R5: Configuration word 2 fields are: second divider D1 in bits [7:0], fractional divider DF in bits [17:8]. DF is used only when bit 18 is 1 and is taken as 0 otherwise.
- R6: The result is `freq_o` = the low 16 bits of floor(((M*1000+MF)*1000*100) / ((D0*1000)*(D1*1000+DF))), with `err_o`=0.
- R7: If the denominator is 0, the run ends with `freq_o`=0 and `err_o`=2, and no division is performed.
- R8: `done_o` is high for exactly one cycle per run. `freq_o` and `err_o` change only in that cycle.
- R9: A start pulse that arrives while a run is in progress is ignored and produces no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a decode run (ignored unless idle) |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Register address of the current read |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle result strobe |
| freq_o | output | FREQ_W | Decoded frequency in MHz |
| err_o | output | 2 | 0 = good, 1 = synthesizer busy, 2 = zero denominator |

## Verification
The decode is tried with several kinds of configuration words:
- Plain integer multiplier and dividers, which check the base formula.
- Words whose fractional fields are nonzero while their flag bit is clear, which show that the flags gate the fractions.
- The same fields with the flags set, which show that each fraction lands in the correct term (multiplier versus second divider).
- A tiny fractional second divider whose quotient overflows 16 bits, which shows truncation.
- Zero dividers, which separate the zero-denominator error from a fractional-only second divider that is still nonzero.

Busy status values, read latencies from 0 to 3 cycles and a start pulse issued in the middle of a run check the read order, the skipped reads and the single result.

// File: rtl/freq_dec_pkg.sv
package freq_dec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_CFG0,
        ST_RD_CFG2,
        ST_CHECK,
        ST_DIV
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_BUSY     = 2'd1,
        ERR_ZERO_DIV = 2'd2
    } dec_err_e;

endpackage

// File: rtl/freq_cfg_decode.sv
// Field extraction and fixed-point scaling of the two configuration words.
module freq_cfg_decode #(
    parameter int PROD_W  = 64,
    parameter int SCALE   = 1000,
    parameter int REF_MHZ = 100
) (
    input  logic [31:0]       cfg0_i,
    input  logic [31:0]       cfg2_i,
    output logic [PROD_W-1:0] numer_o,
    output logic [PROD_W-1:0] denom_o
);
    localparam logic [PROD_W-1:0] SCALE_W = PROD_W'(SCALE);
    localparam logic [PROD_W-1:0] REF_W   = PROD_W'(REF_MHZ);

    logic [7:0]        mul_int, div0_int, div1_int;
    logic [9:0]        mul_frac, div1_frac;
    logic [PROD_W-1:0] mul_fx, div0_fx, div1_fx;
    logic              unused_cfg_bits;

    always_comb begin
        mul_int   = cfg0_i[15:8];
        div0_int  = cfg0_i[7:0];
        mul_frac  = cfg0_i[26] ? cfg0_i[25:16] : 10'd0;
        div1_int  = cfg2_i[7:0];
        div1_frac = cfg2_i[18] ? cfg2_i[17:8] : 10'd0;

        mul_fx  = PROD_W'(mul_int) * SCALE_W + PROD_W'(mul_frac);
        div0_fx = PROD_W'(div0_int) * SCALE_W;
        div1_fx = PROD_W'(div1_int) * SCALE_W + PROD_W'(div1_frac);

        numer_o = mul_fx * SCALE_W * REF_W;
        denom_o = div0_fx * div1_fx;
    end

    assign unused_cfg_bits = ^{cfg0_i[31:27], cfg2_i[31:19]};

endmodule

// File: rtl/freq_restoring_div.sv
// Restoring shift-subtract divider: one quotient bit per cycle, W cycles.
module freq_restoring_div #(
    parameter int W = 64
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [W-1:0] numer_i,
    input  logic [W-1:0] denom_i,
    output logic         done_o,
    output logic [W-1:0] quot_o
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic [W:0]       rem;
        logic [W-1:0]     quot;
        logic [W-1:0]     den;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             done;
    } div_regs_t;

    div_regs_t r_q, r_d;
    logic [W:0] shifted;

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        shifted = {r_q.rem[W-1:0], r_q.quot[W-1]};
        if (start_i && !r_q.run) begin
            r_d.rem  = '0;
            r_d.quot = numer_i;
            r_d.den  = denom_i;
            r_d.cnt  = CNT_W'(W - 1);
            r_d.run  = 1'b1;
        end else if (r_q.run) begin
            if (shifted >= {1'b0, r_q.den}) begin
                r_d.rem  = shifted - {1'b0, r_q.den};
                r_d.quot = {r_q.quot[W-2:0], 1'b1};
            end else begin
                r_d.rem  = shifted;
                r_d.quot = {r_q.quot[W-2:0], 1'b0};
            end
            if (r_q.cnt == '0) begin
                r_d.run  = 1'b0;
                r_d.done = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign done_o = r_q.done;
    assign quot_o = r_q.quot;

endmodule

// File: rtl/synth_freq_decoder.sv
module synth_freq_decoder #(
    parameter int                ADDR_W      = 12,
    parameter int                FREQ_W      = 16,
    parameter int                PROD_W      = 64,
    parameter int                SCALE       = 1000,
    parameter int                REF_MHZ     = 100,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h004,
    parameter logic [ADDR_W-1:0] CFG0_ADDR   = 12'h200,
    parameter logic [ADDR_W-1:0] CFG2_ADDR   = 12'h208
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [31:0]       rd_data_i,
    output logic              done_o,
    output logic [FREQ_W-1:0] freq_o,
    output logic [1:0]        err_o
);
    import freq_dec_pkg::*;

    typedef struct packed {
        seq_state_e        state;
        logic [31:0]       cfg0;
        logic [31:0]       cfg2;
        logic [FREQ_W-1:0] freq;
        dec_err_e          err;
        logic              done;
    } top_regs_t;

    top_regs_t r_q, r_d;

    logic [PROD_W-1:0] numer, denom, quot;
    logic              div_start, div_done;
    logic              unused_quot_bits;

    freq_cfg_decode #(
        .PROD_W (PROD_W),
        .SCALE  (SCALE),
        .REF_MHZ(REF_MHZ)
    ) u_decode (
        .cfg0_i (r_q.cfg0),
        .cfg2_i (r_q.cfg2),
        .numer_o(numer),
        .denom_o(denom)
    );

    freq_restoring_div #(
        .W(PROD_W)
    ) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(div_start),
        .numer_i(numer),
        .denom_i(denom),
        .done_o (div_done),
        .quot_o (quot)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        div_start = 1'b0;
        rd_req_o  = 1'b0;
        rd_addr_o = STATUS_ADDR;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) r_d.state = ST_RD_STAT;
            end
            ST_RD_STAT: begin
                rd_req_o  = 1'b1;
                rd_addr_o = STATUS_ADDR;
                if (rd_ack_i) begin
                    if (rd_data_i[0]) begin
                        r_d.state = ST_RD_CFG0;
                    end else begin
                        r_d.freq  = '0;
                        r_d.err   = ERR_BUSY;
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_RD_CFG0: begin
                rd_req_o  = 1'b1;
                rd_addr_o = CFG0_ADDR;
                if (rd_ack_i) begin
                    r_d.cfg0  = rd_data_i;
                    r_d.state = ST_RD_CFG2;
                end
            end
            ST_RD_CFG2: begin
                rd_req_o  = 1'b1;
                rd_addr_o = CFG2_ADDR;
                if (rd_ack_i) begin
                    r_d.cfg2  = rd_data_i;
                    r_d.state = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (denom == '0) begin
                    r_d.freq  = '0;
                    r_d.err   = ERR_ZERO_DIV;
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    div_start = 1'b1;
                    r_d.state = ST_DIV;
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    r_d.freq  = quot[FREQ_W-1:0];
                    r_d.err   = ERR_NONE;
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.err   <= ERR_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = r_q.done;
    assign freq_o = r_q.freq;
    assign err_o  = r_q.err;
    assign unused_quot_bits = ^quot[PROD_W-1:FREQ_W];

endmodule

// File: rtl/freq_decoder_checker.sv
module freq_decoder_checker #(
    parameter int                ADDR_W      = 12,
    parameter int                FREQ_W      = 16,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h004,
    parameter logic [ADDR_W-1:0] CFG0_ADDR   = 12'h200,
    parameter logic [ADDR_W-1:0] CFG2_ADDR   = 12'h208
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              done_o,
    input logic [FREQ_W-1:0] freq_o,
    input logic [1:0]        err_o
);
    assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

    assert_addr_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_o |-> (rd_addr_o == STATUS_ADDR || rd_addr_o == CFG0_ADDR ||
                      rd_addr_o == CFG2_ADDR));

    assert_busy_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && err_o == 2'd1 |-> freq_o == '0);

    assert_zero_div_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && err_o == 2'd2 |-> freq_o == '0);

    assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(freq_o) && $stable(err_o));

    assert_no_req_at_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !rd_req_o);

endmodule

bind synth_freq_decoder freq_decoder_checker #(
    .ADDR_W     (ADDR_W),
    .FREQ_W     (FREQ_W),
    .STATUS_ADDR(STATUS_ADDR),
    .CFG0_ADDR  (CFG0_ADDR),
    .CFG2_ADDR  (CFG2_ADDR)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_req_o (rd_req_o),
    .rd_addr_o(rd_addr_o),
    .rd_ack_i (rd_ack_i),
    .done_o   (done_o),
    .freq_o   (freq_o),
    .err_o    (err_o)
);

// File: tb/tb_synth_freq_decoder.sv
`timescale 1ns/1ps
module tb_synth_freq_decoder;

    localparam logic [11:0] A_STAT = 12'h004;
    localparam logic [11:0] A_CFG0 = 12'h200;
    localparam logic [11:0] A_CFG2 = 12'h208;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_req_o;
    logic [11:0] rd_addr_o;
    logic        rd_ack_i = 1'b0;
    logic [31:0] rd_data_i = '0;
    logic        done_o;
    logic [15:0] freq_o;
    logic [1:0]  err_o;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [15:0] freq;
        logic [1:0]  err;
        string       tag;
    } exp_item_t;

    exp_item_t   sb_q[$];
    logic [11:0] addr_log[$];
    logic [31:0] mem_stat, mem_c0, mem_c2;
    int          lat = 0;
    int          wait_cnt = 0;
    logic [15:0] last_freq = '0;
    logic [1:0]  last_err = '0;

    synth_freq_decoder dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
        .rd_data_i(rd_data_i), .done_o(done_o), .freq_o(freq_o), .err_o(err_o)
    );

    always #4 clk_i = ~clk_i;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Reference model of R4..R7
    function automatic void model(input logic [31:0] c0, input logic [31:0] c2,
                                  output logic [15:0] f, output logic [1:0] e);
        longint unsigned m, mf, d0, d1, df, num, den, q;
        m  = longint'(c0[15:8]);
        d0 = longint'(c0[7:0]);
        mf = c0[26] ? longint'(c0[25:16]) : 0;
        d1 = longint'(c2[7:0]);
        df = c2[18] ? longint'(c2[17:8]) : 0;
        num = (m * 1000 + mf) * 1000 * 100;
        den = (d0 * 1000) * (d1 * 1000 + df);
        if (den == 0) begin
            f = '0; e = 2'd2;
        end else begin
            q = num / den;
            f = q[15:0]; e = 2'd0;
        end
    endfunction

    // Read responder
    initial begin
        forever begin
            @(negedge clk_i);
            if (rd_ack_i) begin
                rd_ack_i = 1'b0;
            end else if (rd_req_o) begin
                if (wait_cnt >= lat) begin
                    rd_ack_i = 1'b1;
                    rd_data_i = (rd_addr_o == A_STAT) ? mem_stat :
                                (rd_addr_o == A_CFG0) ? mem_c0 :
                                (rd_addr_o == A_CFG2) ? mem_c2 : 32'hDEAD_BEEF;
                    addr_log.push_back(rd_addr_o);
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk_i);
            if (rst_ni && done_o) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected result strobe", 1, 0);
                end else begin
                    exp_item_t it;
                    it = sb_q.pop_front();
                    check(freq_o == it.freq, "R6", {it.tag, " freq"}, freq_o, it.freq);
                    check(err_o == it.err, "R7", {it.tag, " err"}, err_o, it.err);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8ns * 150000);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic run_case(input logic [31:0] st, input logic [31:0] c0,
                            input logic [31:0] c2, input int l, input string tag,
                            input bit restart);
        exp_item_t it;
        logic [15:0] f;
        logic [1:0]  e;
        int n;
        mem_stat = st; mem_c0 = c0; mem_c2 = c2; lat = l;
        if (!st[0]) begin
            f = '0; e = 2'd1;
        end else begin
            model(c0, c2, f, e);
        end
        it.freq = f; it.err = e; it.tag = tag;
        sb_q.push_back(it);
        addr_log.delete();
        @(negedge clk_i) start_i = 1'b1;
        @(negedge clk_i) start_i = 1'b0;
        if (restart) begin
            repeat (3) @(negedge clk_i);
            start_i = 1'b1;
            @(negedge clk_i) start_i = 1'b0;
        end
        n = 0;
        while (sb_q.size() != 0 && n < 2000) begin
            @(negedge clk_i);
            n++;
        end
        repeat (2) @(negedge clk_i);
        last_freq = f; last_err = e;
        if (!st[0]) begin
            check(addr_log.size() == 1, "R3", {tag, " reads on busy"}, addr_log.size(), 1);
        end else begin
            check(addr_log.size() == 3 && addr_log[0] == A_STAT &&
                  addr_log[1] == A_CFG0 && addr_log[2] == A_CFG2,
                  "R2", {tag, " read order/count"}, addr_log.size(), 3);
        end
    endtask

    initial begin
        mem_stat = 32'h1; mem_c0 = '0; mem_c2 = '0;
        repeat (3) @(negedge clk_i);
        // R1 reset state
        check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
        check(rd_req_o == 1'b0, "R1", "req after reset", rd_req_o, 0);
        check(freq_o == '0, "R1", "freq after reset", freq_o, 0);
        check(err_o == '0, "R1", "err after reset", err_o, 0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);

        // R6 integer path: 16*100/80 = 20
        run_case(32'h1, 32'h0000_1001, 32'h0000_0050, 0, "R6 int 20", 1'b0);
        // R4 fraction present but flag clear: 15*100/21 = 71
        run_case(32'h1, 32'h02EE_0F01, 32'h0000_0015, 1, "R4 flag off", 1'b0);
        // R4 flag set: 15.5*100/21 = 73
        run_case(32'h1, 32'h05F4_0F01, 32'h0000_0015, 2, "R4 flag on", 1'b0);
        // R5 fraction ignored without bit 18: 1600/5 = 320
        run_case(32'h1, 32'h0000_1001, 32'h0001_F405, 0, "R5 flag off", 1'b0);
        // R5 fraction used: 1600/5.5 = 290
        run_case(32'h1, 32'h0000_1001, 32'h0005_F405, 3, "R5 flag on", 1'b0);
        // R5 fractional-only D1 nonzero: 1600/0.5 = 3200
        run_case(32'h1, 32'h0000_1001, 32'h0005_F400, 1, "R5 frac only", 1'b0);
        // R6 truncation to 16 bits: 1600/0.001
        run_case(32'h1, 32'h0000_1001, 32'h0004_0100, 0, "R6 truncate", 1'b0);
        // R6 zero multiplier
        run_case(32'h1, 32'h0000_0003, 32'h0000_0002, 0, "R6 zero mult", 1'b0);
        // R7 zero D0
        run_case(32'h1, 32'h0000_1000, 32'h0000_0010, 0, "R7 d0 zero", 1'b0);
        // R7 zero D1 with flag clear but fraction bits set
        run_case(32'h1, 32'h0000_1001, 32'h0001_F400, 2, "R7 d1 zero", 1'b0);
        // R3 busy: status 0 and status 2
        run_case(32'h0, 32'h0000_1001, 32'h0000_0050, 1, "R3 busy0", 1'b0);
        run_case(32'h2, 32'h0000_1001, 32'h0000_0050, 0, "R3 busy2", 1'b0);
        // R9 restart during a run is ignored: 1600/8 = 200
        run_case(32'h1, 32'h0000_1001, 32'h0000_0008, 3, "R9 restart", 1'b1);
        repeat (100) @(negedge clk_i);
        check(sb_q.size() == 0, "R9", "pending items after restart", sb_q.size(), 0);
        // R8 result held between runs
        check(freq_o == last_freq, "R8", "freq held", freq_o, last_freq);
        check(err_o == last_err, "R8", "err held", err_o, last_err);
        check(done_o == 1'b0, "R8", "done low when idle", done_o, 0);
        finish_run();
    end

endmodule